// File: doc/BRIEF.md
# Dual-Clock Request/Acknowledge Word Link

This block moves small data words from a producer in one clock domain to a consumer in a second, unrelated clock domain. It uses a four-phase request/acknowledge handshake, so no word is lost and none is delivered twice. The producer side generates a repeating count. It raises a request with the word held stable and keeps both until its synchronized view of the acknowledge goes high. It then drops the request and waits for the acknowledge to clear. After that it idles for a fixed number of its own clock cycles before it presents the next value.

The consumer side synchronizes the request into its own clock. It captures the word once, on the rising edge of the synchronized request. In that same cycle it raises the acknowledge and emits a one-cycle valid strobe with the captured word. The acknowledge follows the synchronized request, so it clears once the request has been seen low. Each handshake signal crosses through a flop chain of parameterized depth. The multi-bit word crosses unsynchronized because it is guaranteed stable while the request is high.

Top module: `xclk_req_ack_link`

## Requirements
- R1: While arst_n is low, hs_req, hs_ack and rx_valid are 0, and hs_word and rx_word are 0.
- R2: After reset is released, hs_req first rises on the GAP_CYC-th rising edge of src_clk, carrying word 0.
- R3: Successive requests carry the values 0, 1, …, SEQ_LEN-1, then wrap to 0, with each value one greater than the last modulo SEQ_LEN.
- R4: hs_word does not change on any src_clk edge while hs_req stays high.
- R5: hs_req falls only after hs_ack has been high, and rises only while hs_ack is low.
- R6: After hs_ack falls, hs_req rises again on exactly the (SYNC_STAGES+1+GAP_CYC)-th src_clk rising edge.
- R7: rx_valid is high for exactly one dst_clk cycle per request. It is set on the (SYNC_STAGES+1)-th dst_clk rising edge after hs_req rises.
- R8: hs_ack rises in the same dst_clk cycle as rx_valid. It falls on the (SYNC_STAGES+1)-th dst_clk rising edge after hs_req falls, and only while hs_req is low.
- R9: Across clock ratios in both directions, the words presented on rx_word with rx_valid form the sequence 0..SEQ_LEN-1 repeating, with no gaps or duplicates, and there is one strobe per request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Producer-side clock |
| dst_clk | input | 1 | Consumer-side clock, unrelated to src_clk |
| arst_n | input | 1 | Asynchronous reset for both sides, active low |
| hs_req | output | 1 | Request driven by the producer (src_clk domain) |
| hs_ack | output | 1 | Acknowledge driven by the consumer (dst_clk domain) |
| hs_word | output | WORD_W | Word offered by the producer, stable while hs_req is high |
| rx_valid | output | 1 | One-cycle strobe in dst_clk marking a newly captured word |
| rx_word | output | WORD_W | Last word captured by the consumer |

## Verification
Every latency is stated in edges of the clock that owns the result. The strobe and acknowledge follow a request edge by SYNC_STAGES+1 consumer edges. The next request follows an acknowledge fall by SYNC_STAGES+1+GAP_CYC producer edges. The first request follows reset release by GAP_CYC producer edges. The bench zeroes an edge counter at each handshake transition and compares the count when the result appears. It samples on the falling edge of the owning clock, and both clocks are phased so their edges never coincide. This makes every count exact for dst_clk slower than, faster than and close to src_clk.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;

   // producer handshake phases
   typedef enum logic [1:0] {
      TX_GAP   = 2'd0,   // idle spacing after a completed transfer
      TX_HOLD  = 2'd1,   // request high, word frozen
      TX_DRAIN = 2'd2    // request low, waiting for acknowledge to clear
   } tx_state_e;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[i] <= 1'b0;
            else         chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[i] <= 1'b0;
            else         chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hs_tx.sv
module hs_tx
   import hs_link_pkg::*;
#(
   parameter int WORD_W      = 4,
   parameter int SEQ_LEN     = 8,
   parameter int GAP_CYC     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              ack_in,
   output logic              req_o,
   output logic [WORD_W-1:0] word_o
);

   localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam logic [CNT_W-1:0]  GAP_LAST  = CNT_W'(GAP_CYC - 1);
   localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(SEQ_LEN - 1);

   logic              ack_s;
   tx_state_e         st;
   logic [CNT_W-1:0]  gap_cnt;
   logic              req_q;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_nx;

   hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (ack_in),
      .q      (ack_s)
   );

   // a full power-of-two sequence wraps by overflow; otherwise compare
   if (SEQ_LEN == (1 << WORD_W)) begin : g_wrap_natural
      assign word_nx = word_q + 1'b1;
   end else begin : g_wrap_cmp
      assign word_nx = (word_q == WORD_LAST) ? '0 : word_q + 1'b1;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st      <= TX_GAP;
         gap_cnt <= '0;
         req_q   <= 1'b0;
         word_q  <= '0;
      end else begin
         case (st)
            TX_GAP: begin
               if (gap_cnt == GAP_LAST) begin
                  st    <= TX_HOLD;
                  req_q <= 1'b1;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            TX_HOLD: begin
               if (ack_s) begin
                  st    <= TX_DRAIN;
                  req_q <= 1'b0;
               end
            end
            TX_DRAIN: begin
               if (!ack_s) begin
                  st      <= TX_GAP;
                  gap_cnt <= '0;
                  word_q  <= word_nx;
               end
            end
            default: begin
               st    <= TX_GAP;
               req_q <= 1'b0;
            end
         endcase
      end
   end

   assign req_o  = req_q;
   assign word_o = word_q;

endmodule

// File: rtl/hs_rx.sv
module hs_rx #(
   parameter int WORD_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              req_in,
   input  logic [WORD_W-1:0] word_in,
   output logic              ack_o,
   output logic              vld_o,
   output logic [WORD_W-1:0] word_o
);

   logic              req_s;
   logic              ack_q;
   logic              vld_q;
   logic [WORD_W-1:0] word_q;
   logic              take;

   hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (req_in),
      .q      (req_s)
   );

   // ack_q is req_s one cycle late, so it doubles as the edge detector
   assign take = req_s & ~ack_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         ack_q  <= 1'b0;
         vld_q  <= 1'b0;
         word_q <= '0;
      end else begin
         ack_q <= req_s;
         vld_q <= take;
         if (take) word_q <= word_in;
      end
   end

   assign ack_o  = ack_q;
   assign vld_o  = vld_q;
   assign word_o = word_q;

endmodule

// File: rtl/xclk_req_ack_link.sv
module xclk_req_ack_link #(
   parameter int WORD_W      = 4,
   parameter int SEQ_LEN     = 8,
   parameter int GAP_CYC     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              src_clk,
   input  logic              dst_clk,
   input  logic              arst_n,
   output logic              hs_req,
   output logic              hs_ack,
   output logic [WORD_W-1:0] hs_word,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_word
);

   if (WORD_W < 1 || WORD_W > 16) begin : g_bad_width
      $error("WORD_W must lie in 1..16");
   end
   if (SEQ_LEN < 2 || SEQ_LEN > (1 << WORD_W)) begin : g_bad_seq
      $error("SEQ_LEN must lie in 2..2**WORD_W");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   hs_tx #(
      .WORD_W      (WORD_W),
      .SEQ_LEN     (SEQ_LEN),
      .GAP_CYC     (GAP_CYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tx (
      .clk    (src_clk),
      .arst_n (arst_n),
      .ack_in (hs_ack),
      .req_o  (hs_req),
      .word_o (hs_word)
   );

   hs_rx #(
      .WORD_W      (WORD_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk     (dst_clk),
      .arst_n  (arst_n),
      .req_in  (hs_req),
      .word_in (hs_word),
      .ack_o   (hs_ack),
      .vld_o   (rx_valid),
      .word_o  (rx_word)
   );

endmodule

// File: rtl/xclk_req_ack_link_chk.sv
module xclk_req_ack_link_chk #(
   parameter int WORD_W      = 4,
   parameter int SEQ_LEN     = 8,
   parameter int GAP_CYC     = 5,
   parameter int SYNC_STAGES = 2
) (
   input logic              src_clk,
   input logic              dst_clk,
   input logic              arst_n,
   input logic              hs_req,
   input logic              hs_ack,
   input logic [WORD_W-1:0] hs_word,
   input logic              rx_valid,
   input logic [WORD_W-1:0] rx_word
);

   logic [WORD_W-1:0] exp_q;
   logic [WORD_W:0]   exp_inc;

   assign exp_inc = {1'b0, exp_q} + 1'b1;

   always_ff @(posedge dst_clk or negedge arst_n) begin
      if (!arst_n)       exp_q <= '0;
      else if (rx_valid) exp_q <= (exp_inc == (WORD_W+1)'(SEQ_LEN)) ? '0 : exp_inc[WORD_W-1:0];
   end

   // R4
   word_hold_chk: assert property (@(posedge src_clk) disable iff (!arst_n)
      (hs_req && $past(hs_req)) |-> (hs_word == $past(hs_word)));

   // R3
   word_range_chk: assert property (@(posedge src_clk) disable iff (!arst_n)
      hs_req |-> ({1'b0, hs_word} < (WORD_W+1)'(SEQ_LEN)));

   // R5
   req_drop_chk: assert property (@(posedge src_clk) disable iff (!arst_n)
      $fell(hs_req) |-> $past(hs_ack));

   // R5
   req_raise_chk: assert property (@(posedge src_clk) disable iff (!arst_n)
      $rose(hs_req) |-> !$past(hs_ack));

   // R7
   strobe_pulse_chk: assert property (@(posedge dst_clk) disable iff (!arst_n)
      rx_valid |=> !rx_valid);

   // R8
   ack_with_strobe_chk: assert property (@(posedge dst_clk) disable iff (!arst_n)
      rx_valid |-> $rose(hs_ack));

   // R8
   ack_release_chk: assert property (@(posedge dst_clk) disable iff (!arst_n)
      $fell(hs_ack) |-> !$past(hs_req));

   // R9
   rx_order_chk: assert property (@(posedge dst_clk) disable iff (!arst_n)
      rx_valid |-> (rx_word == exp_q));

endmodule

bind xclk_req_ack_link xclk_req_ack_link_chk #(
   .WORD_W      (WORD_W),
   .SEQ_LEN     (SEQ_LEN),
   .GAP_CYC     (GAP_CYC),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .src_clk  (src_clk),
   .dst_clk  (dst_clk),
   .arst_n   (arst_n),
   .hs_req   (hs_req),
   .hs_ack   (hs_ack),
   .hs_word  (hs_word),
   .rx_valid (rx_valid),
   .rx_word  (rx_word)
);

// File: tb/xclk_req_ack_link_test.sv
`timescale 1ns/10ps
module xclk_req_ack_link_test;

   localparam int WORD_W  = 4;
   localparam int SEQ_LEN = 8;
   localparam int GAP     = 5;
   localparam int SYNC    = 2;
   localparam int WORDS   = 24;
   localparam int WD_LIMIT = 150000;

   logic              src_clk = 1'b0;
   logic              dst_clk = 1'b0;
   logic              arst_n  = 1'b0;
   logic              hs_req, hs_ack, rx_valid;
   logic [WORD_W-1:0] hs_word, rx_word;

   xclk_req_ack_link #(
      .WORD_W(WORD_W), .SEQ_LEN(SEQ_LEN), .GAP_CYC(GAP), .SYNC_STAGES(SYNC)
   ) uut (
      .src_clk(src_clk), .dst_clk(dst_clk), .arst_n(arst_n),
      .hs_req(hs_req), .hs_ack(hs_ack), .hs_word(hs_word),
      .rx_valid(rx_valid), .rx_word(rx_word)
   );

   real dhalf = 5.25;
   always #2 src_clk = ~src_clk;
   initial begin
      #0.3;
      forever #(dhalf) dst_clk = ~dst_clk;
   end

   int checks = 0, errors = 0;
   int cyc = 0;
   bit wd_hit = 0;
   bit mon_en = 0;
   bit first_req;
   int s_cnt, d_rise_cnt, d_fall_cnt;
   int exp_tx, exp_rx, nrx, nreq;
   logic p_req, p_vld, p_ack;
   logic [WORD_W-1:0] p_word;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   always @(posedge src_clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !wd_hit) begin
         wd_hit = 1;
         chk(0, "watchdog", cyc, WD_LIMIT);
      end
   end

   // edge counters restarted by handshake transitions
   always @(negedge hs_ack) s_cnt = 0;
   always @(posedge src_clk) s_cnt++;
   always @(posedge hs_req) d_rise_cnt = 0;
   always @(negedge hs_req) d_fall_cnt = 0;
   always @(posedge dst_clk) begin
      d_rise_cnt++;
      d_fall_cnt++;
   end

   // producer-side monitor
   always @(negedge src_clk) begin
      if (mon_en) begin
         if (hs_req && !p_req) begin
            if (first_req) chk(s_cnt == GAP, "R2", s_cnt, GAP);
            else           chk(s_cnt == SYNC + 1 + GAP, "R6", s_cnt, SYNC + 1 + GAP);
            first_req = 0;
            chk(int'(hs_word) == exp_tx, "R3", int'(hs_word), exp_tx);
            exp_tx = (exp_tx + 1) % SEQ_LEN;
            nreq++;
         end
         if (hs_req && p_req) chk(hs_word == p_word, "R4", int'(hs_word), int'(p_word));
         if (!hs_req && p_req) chk(hs_ack == 1'b1, "R5", int'(hs_ack), 1);
         p_req  = hs_req;
         p_word = hs_word;
      end
   end

   // consumer-side monitor
   always @(negedge dst_clk) begin
      if (mon_en) begin
         if (rx_valid) begin
            chk(d_rise_cnt == SYNC + 1, "R7", d_rise_cnt, SYNC + 1);
            chk(!p_vld, "R7", int'(p_vld), 0);
            chk(hs_ack == 1'b1, "R8", int'(hs_ack), 1);
            chk(int'(rx_word) == exp_rx, "R9", int'(rx_word), exp_rx);
            exp_rx = (exp_rx + 1) % SEQ_LEN;
            nrx++;
         end
         if (p_ack && !hs_ack) chk(d_fall_cnt == SYNC + 1, "R8", d_fall_cnt, SYNC + 1);
         p_vld = rx_valid;
         p_ack = hs_ack;
      end
   end

   task automatic run_phase(input real half);
      mon_en = 0;
      arst_n = 1'b0;
      dhalf  = half;
      repeat (3) @(negedge src_clk);
      chk(hs_req == 1'b0,   "R1", int'(hs_req), 0);
      chk(hs_ack == 1'b0,   "R1", int'(hs_ack), 0);
      chk(rx_valid == 1'b0, "R1", int'(rx_valid), 0);
      chk(hs_word == '0,    "R1", int'(hs_word), 0);
      chk(rx_word == '0,    "R1", int'(rx_word), 0);
      exp_tx = 0; exp_rx = 0; nrx = 0; nreq = 0; first_req = 1;
      p_req = 0; p_vld = 0; p_ack = 0; p_word = '0;
      #0.7;
      arst_n = 1'b1;
      s_cnt  = 0;
      mon_en = 1;
      while (nrx < WORDS && !wd_hit) @(negedge src_clk);
      // R9: one strobe per request, at most one request still in flight
      chk((nreq - nrx) inside {0, 1}, "R9", nreq - nrx, 0);
   endtask

   initial begin
      run_phase(5.25);   // consumer slower
      run_phase(1.25);   // consumer faster
      run_phase(3.25);
      run_phase(2.25);   // near-equal rates
      mon_en = 0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule